// File: doc/BRIEF.md
# Dynamic Bus Sizing Interface

This block is a bus master that turns one internal operand request (one, two, three or four bytes) into a series of external asynchronous bus cycles. Each cycle starts with an address phase. In that phase the block drives the byte address, the remaining-byte size code, the function code and the direction, with both strobes low. Next it raises the address strobe and the data strobe together and holds them until the addressed device returns a two-bit data-size acknowledge.

The acknowledge tells the block whether the device port is 8 or 16 bits wide. From that, and from the low address bit, the block decides how many bytes this cycle moved. It then steps the address, lowers the remaining count and, if bytes are left, starts the next cycle. Write bytes are steered onto the lanes that either port width would pick up. Read bytes are collected into a right-aligned, big-endian result. The number of cycles is therefore settled only at run time.

The owner hands in a request when `req_ready` is high and gets a one-clock `op_done` pulse when the operand is complete.

Top module: `dyn_bus_master`

## Requirements
- R1: While reset is held, the block is idle. `req_ready`=1, `bus_as`=0, `bus_ds`=0, `bus_doe`=0, `op_done`=0, and `bus_rw`=1 (1 means read, 0 means write).
- R2: Every bus cycle begins with one clock in which address, size, function code and direction are valid and both strobes are low. Then `bus_as` and `bus_ds` rise together and stay high until an accepted acknowledge. `bus_fc` carries the request's function code for the whole operation.
- R3: `bus_siz` gives the operand bytes still to move: 01 = one, 10 = two, 11 = three, 00 = four.
- R4: `bus_dsack`=01 means an 8-bit port and `bus_dsack`=10 means a 16-bit port. 00 and 11 are both ignored. The strobes stay high and the address and size stay unchanged until a legal code arrives.
- R5: An 8-bit port moves one byte. A 16-bit port at an odd address moves one byte. A 16-bit port at an even address moves two bytes, or one byte if only one remains.
- R6: After each acknowledge, the address grows by the bytes moved. Cycles repeat until no bytes remain. `op_done` is then high for exactly one clock, and `req_ready` is high again on the next clock.
- R7: On writes, the operand's bytes go out most significant first. At an even address, the upper lane `bus_dout[15:8]` holds the next byte and the lower lane holds the byte after it. At an odd address, both lanes hold the next byte. `bus_doe` is high during write operations only.
- R8: On reads, an 8-bit port is read on the upper lane. A 16-bit port is read on the upper lane for an even address and on the lower lane for an odd address; with two bytes at an even address, upper comes before lower. `op_rdata` holds the bytes right-aligned with the first byte most significant. It is valid at `op_done` and held until the next request.
- R9: `bus_rw` changes only when a request is accepted. It stays low across back-to-back writes, including the idle gaps between them.
- R10: `req_size` uses the same code as R3. A request presented while `req_ready` is low has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand length code (01/10/11/00 = 1/2/3/4 bytes) |
| req_addr | input | ADDR_W | Byte address of the first operand byte |
| req_fc | input | FC_W | Function code for the operation |
| req_wdata | input | 32 | Write operand, right-aligned |
| req_ready | output | 1 | Idle and able to take a request |
| op_done | output | 1 | One-clock completion pulse |
| op_rdata | output | 32 | Assembled read operand, right-aligned |
| bus_addr | output | ADDR_W | External byte address |
| bus_siz | output | 2 | Remaining-byte code |
| bus_fc | output | FC_W | External function code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_dout | output | 16 | Write data lanes |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data lanes |
| bus_dsack | input | 2 | Data-size acknowledge |

## Verification
The bench builds the block with its default parameters: a 24-bit address and a 3-bit function code. Its device model decodes only the low eight address bits. That range is enough to place operands at every even and odd alignment and to carry a three-byte transfer across a halfword boundary. Because the port width, the wait-state count and the injection of the illegal acknowledge are switched per operation, every step rule and every lane choice is reached for 8-bit and 16-bit devices alike.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;
  localparam int LANE_W   = 8;
  localparam int BUS_W    = 16;
  localparam int LANES    = BUS_W / LANE_W;
  localparam int OP_BYTES = 4;
  localparam int OP_W     = OP_BYTES * LANE_W;
  localparam int CNT_W    = $clog2(OP_BYTES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_STRB} seq_st_t;

  // operand length in bytes from the two-bit code (00 means four)
  function automatic logic [CNT_W-1:0] len_of(input logic [1:0] code);
    return (code == 2'b00) ? CNT_W'(OP_BYTES) : CNT_W'(code);
  endfunction

  // remaining-byte count to the external size code
  function automatic logic [1:0] siz_of(input logic [CNT_W-1:0] rem);
    return rem[1:0];
  endfunction

  // bytes moved by one acknowledged cycle
  function automatic logic [CNT_W-1:0] step_of(input logic wide, input logic a0,
                                               input logic [CNT_W-1:0] rem);
    if (!wide || a0 || rem == CNT_W'(1)) return CNT_W'(1);
    return CNT_W'(2);
  endfunction
endpackage

// File: rtl/dbs_seq.sv
`timescale 1ns/1ps
module dbs_seq
  import dbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ack_ok,
  input  logic    last,
  output seq_st_t st,
  output logic    ready,
  output logic    as_o,
  output logic    ds_o,
  output logic    done,
  output logic    ack_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) st <= ST_ADDR;
        ST_ADDR: st <= ST_STRB;
        ST_STRB: if (ack_ok) begin
          if (last) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st <= ST_ADDR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ready   = (st == ST_IDLE);
  assign as_o    = (st == ST_STRB);
  assign ds_o    = (st == ST_STRB);
  assign ack_evt = (st == ST_STRB) && ack_ok;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);  // R6
endmodule

// File: rtl/dbs_lane_steer.sv
`timescale 1ns/1ps
module dbs_lane_steer
  import dbs_pkg::*;
(
  input  logic [BUS_W-1:0] head,
  input  logic             a0,
  output logic [BUS_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = BUS_W - 1 - LANE_W * g;
    if (g == 0) begin : g_up
      assign dout[HI -: LANE_W] = head[BUS_W-1 -: LANE_W];
    end else begin : g_lo
      assign dout[HI -: LANE_W] = a0 ? head[BUS_W-1 -: LANE_W] : head[HI -: LANE_W];
    end
  end
endmodule

// File: rtl/dbs_rd_pack.sv
`timescale 1ns/1ps
module dbs_rd_pack
  import dbs_pkg::*;
(
  input  logic [BUS_W-1:0] din,
  input  logic             wide,
  input  logic             a0,
  input  logic [CNT_W-1:0] step,
  input  logic [OP_W-1:0]  acc,
  output logic [OP_W-1:0]  acc_nxt
);
  logic [LANE_W-1:0] pick;
  always_comb begin
    pick = (wide && a0) ? din[LANE_W-1:0] : din[BUS_W-1 -: LANE_W];
    if (step == CNT_W'(2)) acc_nxt = {acc[OP_W-BUS_W-1:0], din};
    else                   acc_nxt = {acc[OP_W-LANE_W-1:0], pick};
  end
endmodule

// File: rtl/dyn_bus_master.sv
`timescale 1ns/1ps
module dyn_bus_master
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [FC_W-1:0]   req_fc,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              op_done,
  output logic [31:0]       op_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [FC_W-1:0]   bus_fc,
  output logic              bus_rw,
  output logic              bus_as,
  output logic              bus_ds,
  output logic [15:0]       bus_dout,
  output logic              bus_doe,
  input  logic [15:0]       bus_din,
  input  logic [1:0]        bus_dsack
);
  seq_st_t           st;
  logic              start, ack_ok, ack_evt, wide, last;
  logic [CNT_W-1:0]  rem_q, tot_q, step, req_len;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic [OP_W-1:0]   wbuf_q, rbuf_q, acc_nxt;
  logic [FC_W-1:0]   fc_q;
  logic              rw_q;

  assign start   = req_valid && req_ready;
  assign wide    = (bus_dsack == 2'b10);
  assign ack_ok  = (bus_dsack == 2'b01) || wide;
  assign step    = step_of(wide, addr_q[0], rem_q);
  assign last    = (step == rem_q);
  assign req_len = len_of(req_size);

  dbs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ack_ok(ack_ok), .last(last),
    .st(st), .ready(req_ready), .as_o(bus_as), .ds_o(bus_ds),
    .done(op_done), .ack_evt(ack_evt)
  );

  dbs_lane_steer u_steer (
    .head(wbuf_q[OP_W-1 -: BUS_W]), .a0(addr_q[0]), .dout(bus_dout)
  );

  dbs_rd_pack u_pack (
    .din(bus_din), .wide(wide), .a0(addr_q[0]), .step(step),
    .acc(rbuf_q), .acc_nxt(acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      base_q <= '0;
      rem_q  <= '0;
      tot_q  <= '0;
      fc_q   <= '0;
      rw_q   <= 1'b1;
      wbuf_q <= '0;
      rbuf_q <= '0;
    end else if (start) begin
      addr_q <= req_addr;
      base_q <= req_addr;
      rem_q  <= req_len;
      tot_q  <= req_len;
      fc_q   <= req_fc;
      rw_q   <= !req_write;
      wbuf_q <= req_wdata << {(CNT_W'(OP_BYTES) - req_len), 3'b000};
      rbuf_q <= '0;
    end else if (ack_evt) begin
      addr_q <= addr_q + ADDR_W'(step);
      rem_q  <= rem_q - step;
      wbuf_q <= wbuf_q << {step, 3'b000};
      rbuf_q <= acc_nxt;
    end
  end

  assign bus_addr = addr_q;
  assign bus_siz  = siz_of(rem_q);
  assign bus_fc   = fc_q;
  assign bus_rw   = rw_q;
  assign bus_doe  = !rw_q && (st != ST_IDLE);
  assign op_rdata = rbuf_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && $past(bus_as)) |-> ($stable(bus_addr) && $stable(bus_siz)));  // R4
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |-> (step != '0 && step <= rem_q));  // R5
  AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> ((bus_addr - base_q) == ADDR_W'(tot_q - rem_q)));  // R6
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (rem_q == '0));  // R6
  AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> $stable(bus_rw));  // R9
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ds |-> bus_as);  // R2
endmodule

// File: tb/sim_dyn_bus_master.sv
`timescale 1ns/1ps
module sim_dyn_bus_master;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_write, req_ready, op_done;
  logic [1:0]  req_size, bus_siz, bus_dsack;
  logic [23:0] req_addr, bus_addr;
  logic [2:0]  req_fc, bus_fc;
  logic [31:0] req_wdata, op_rdata;
  logic        bus_rw, bus_as, bus_ds, bus_doe;
  logic [15:0] bus_dout, bus_din;

  dyn_bus_master u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_fc(req_fc), .req_wdata(req_wdata),
    .req_ready(req_ready), .op_done(op_done), .op_rdata(op_rdata),
    .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_fc(bus_fc), .bus_rw(bus_rw),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_dsack(bus_dsack)
  );

  int checks = 0, fails = 0;
  logic [7:0] mem [0:255];
  logic [7:0] snap [0:255];
  bit port16 = 0, inject_bad = 0, junk_req = 0;
  int nwait = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bytes_now(input bit p16, input logic [23:0] a, input int rem);
    if (p16 && !a[0] && rem >= 2) return 2;
    return 1;
  endfunction

  function automatic int exp_cycles(input bit p16, input logic [23:0] a, input int n);
    int c = 0;
    while (n > 0) begin
      int k = bytes_now(p16, a, n);
      a = a + 24'(k);
      n -= k;
      c++;
    end
    return c;
  endfunction

  // One operation: request, device model, and per-operation checks.
  task automatic do_op(input bit wr, input logic [1:0] code, input logic [23:0] a,
                       input logic [31:0] wd, input string tag);
    int n, rem, ncyc, bad_siz, bad_addr, bad_rw, bad_strb, w;
    logic [23:0] ta;
    logic [31:0] rd, exp;
    bit seen, injected, ok_done;
    n = (code == 2'b00) ? 4 : int'(code);
    rem = n; ta = a; ncyc = 0; bad_siz = 0; bad_addr = 0; bad_rw = 0; bad_strb = 0;
    seen = 0; injected = 0; ok_done = 0; w = 0; rd = '0;
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = code; req_addr = a; req_fc = 3'd5; req_wdata = wd;
    @(negedge clk);
    if (!junk_req) req_valid = 0;
    else begin
      req_write = !wr; req_addr = 24'h0; req_wdata = 32'hDEADBEEF; req_size = 2'b01;
    end
    if (bus_as || bus_ds) bad_strb++;          // R2 address phase first
    for (int it = 0; it < 400; it++) begin
      if (op_done) begin ok_done = 1; rd = op_rdata; break; end
      if (bus_rw != !wr) bad_rw++;
      if (bus_fc != 3'd5) bad_strb++;
      if (bus_ds != bus_as) bad_strb++;
      if (!bus_as) begin
        bus_dsack = 2'b00; seen = 0;
      end else begin
        if (!seen) begin
          seen = 1; w = nwait;
          if (bus_siz != 2'(rem)) bad_siz++;
        end else if (bus_siz != 2'(rem)) bad_siz++;
        if (bus_addr != ta) bad_addr++;
        if (inject_bad && !injected) begin
          bus_dsack = 2'b11; injected = 1;
        end else if (w > 0) begin
          bus_dsack = 2'b00; w--;
        end else begin
          int k = bytes_now(port16, ta, rem);
          bus_dsack = port16 ? 2'b10 : 2'b01;
          if (wr) begin
            if (port16 && ta[0]) mem[ta[7:0]] = bus_dout[7:0];
            else mem[ta[7:0]] = bus_dout[15:8];
            if (k == 2) mem[8'(ta[7:0] + 8'd1)] = bus_dout[7:0];
          end else if (port16) begin
            bus_din = {mem[{ta[7:1], 1'b0}], mem[{ta[7:1], 1'b1}]};
          end else begin
            bus_din = {mem[ta[7:0]], 8'h5A};
          end
          ta = ta + 24'(k); rem -= k; ncyc++;
          req_valid = 0;
        end
      end
      @(negedge clk);
    end
    bus_dsack = 2'b00;
    chk(ok_done, {tag, " R6 completion"}, 32'(ok_done), 32'd1);
    chk(ncyc == exp_cycles(port16, a, n), {tag, " R5 cycle count"}, 32'(ncyc),
        32'(exp_cycles(port16, a, n)));
    chk(bad_siz == 0, {tag, " R3 size code"}, 32'(bad_siz), 32'd0);
    chk(bad_addr == 0, {tag, " R6 address/R4 hold"}, 32'(bad_addr), 32'd0);
    chk(bad_rw == 0, {tag, " R9 direction"}, 32'(bad_rw), 32'd0);
    chk(bad_strb == 0, {tag, " R2 strobes/fc"}, 32'(bad_strb), 32'd0);
    if (wr) begin
      bit ok = 1;
      for (int j = 0; j < n; j++)
        if (mem[8'(a[7:0] + 8'(j))] != wd[8*(n-1-j) +: 8]) ok = 0;
      if (mem[8'(a[7:0] - 8'd1)] != snap[8'(a[7:0] - 8'd1)]) ok = 0;
      if (mem[8'(a[7:0] + 8'(n))] != snap[8'(a[7:0] + 8'(n))]) ok = 0;
      chk(ok, {tag, " R7 written bytes"}, 32'(ok), 32'd1);
    end else begin
      exp = '0;
      for (int j = 0; j < n; j++) exp = {exp[23:0], mem[8'(a[7:0] + 8'(j))]};
      chk(rd == exp, {tag, " R8 read data"}, rd, exp);
    end
    @(negedge clk);
    chk(!op_done && req_ready, {tag, " R6 done pulse"}, {30'd0, op_done, req_ready}, 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_fc = 0;
    req_wdata = 0; bus_din = 0; bus_dsack = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_as && !bus_ds && !bus_doe && !op_done && bus_rw, "R1 reset state",
        {26'd0, req_ready, bus_as, bus_ds, bus_doe, op_done, bus_rw}, 32'h21);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_write_long16();
    port16 = 1; do_op(1, 2'b00, 24'h10, 32'h12345678, "wr long p16 even");
  endtask

  task automatic t_read_long16_odd();
    port16 = 1; do_op(0, 2'b00, 24'h21, 32'h0, "rd long p16 odd");
  endtask

  task automatic t_write_word8();
    port16 = 0; do_op(1, 2'b10, 24'h30, 32'h0000BEEF, "wr word p8");
    chk(bus_rw == 0, "R9 rw stays low while idle after write", 32'(bus_rw), 32'd0);
    port16 = 1; do_op(1, 2'b01, 24'h45, 32'h00000077, "wr byte p16 odd (R7 lower lane)");
  endtask

  task automatic t_read_byte16_odd();
    port16 = 1; do_op(0, 2'b01, 24'h41, 32'h0, "rd byte p16 odd");
    chk(bus_rw == 1, "R9 rw high after read", 32'(bus_rw), 32'd1);
  endtask

  task automatic t_read3_wait_bad();
    port16 = 0; nwait = 2; inject_bad = 1;
    do_op(0, 2'b11, 24'h50, 32'h0, "rd 3B p8 waits R4 R10");
    nwait = 0; inject_bad = 0;
  endtask

  task automatic t_busy_request();
    logic [7:0] m0;
    m0 = mem[0];
    port16 = 1; junk_req = 1;
    do_op(1, 2'b10, 24'h60, 32'h0000C3D4, "wr word p16 busy-req R10");
    junk_req = 0;
    chk(mem[0] == m0, "R10 busy request ignored", 32'(mem[0]), 32'(m0));
  endtask

  task automatic t_write3_odd16();
    port16 = 1; do_op(1, 2'b11, 24'h71, 32'h00A1B2C3, "wr 3B p16 odd");
    port16 = 1; do_op(0, 2'b10, 24'h7F, 32'h0, "rd word p16 odd");
  endtask

  initial begin
    t_reset();
    t_write_long16();
    t_read_long16_odd();
    t_write_word8();
    t_read_byte16_odd();
    t_read3_wait_bad();
    t_busy_request();
    t_write3_odd16();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule